// File: doc/BRIEF.md
# I2C Master Arbitration Loss Detector

This block watches the data line while the unit acts as bus master and transmitter, and decides when another master has won the bus. On every strobe that marks a sample of the data line while the clock is high, the block compares the level the unit wants on the line with the level actually seen. If the unit released the line (wanted a 1) but the line is low, another device pulled it low and arbitration is lost.

On a loss the block raises a sticky arbitration-lost flag and drops transmit mode in the same clock edge. Master mode stays set until the end-of-byte strobe, so the unit keeps clocking in the rest of the byte as a receiver. This lets the address matcher compare another master's address with the unit's own. For the rest of that byte the block asks the pad logic to release the line. The mode bits are loaded by a mode write strobe. The flag is cleared by a write to the data shift register while enabled, by dropping the enable, or by reset.

Top module: `i2c_arb_monitor`

## Requirements
- R1: The raw data line passes through SYNC_STAGES flops (default 2, reset value 1) before comparison. A line change applied one cycle before a sample strobe is not seen at that strobe. It is seen at a strobe SYNC_STAGES cycles after the change.
- R2: A loss is detected on a clock edge only when all of these hold: the enable is 1, master is 1, transmit is 1, the driven value is 1 (released), the synchronized line is 0, and the sample strobe is 1.
- R3: At the edge where a loss is detected, al_o becomes 1 and trx_o becomes 0.
- R4: After a loss, mst_o keeps its value until an edge with byte_end_i high, and it is 0 after that edge. A loss and an end-of-byte strobe at the same edge clear mst_o at that edge.
- R5: With any detection condition of R2 false, al_o does not rise and trx_o and mst_o are unchanged.
- R6: With the enable at 1 and no loss at that edge, a data shift register write clears al_o at the next edge.
- R7: With the enable at 0, al_o is 0 after the next edge. Reset clears al_o, mst_o, trx_o and sda_rel_o.
- R8: sda_rel_o is 1 from the edge after a loss (unless the same edge ends the byte) until the end-of-byte edge, and 0 after it.
- R9: A mode write does not clear al_o.
- R10: A mode write loads mst_o and trx_o from mst_wdat_i and trx_wdat_i. At an edge with both a loss and a mode write, trx_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| mode_wr_i | input | 1 | Mode bit write strobe |
| mst_wdat_i | input | 1 | Master bit write value |
| trx_wdat_i | input | 1 | Transmit bit write value |
| dsr_wr_i | input | 1 | Data shift register write strobe |
| sda_drv_i | input | 1 | Level the unit drives, 1 = released |
| sda_line_i | input | 1 | Raw data line, asynchronous |
| scl_hi_stb_i | input | 1 | Sample strobe while the clock line is high |
| byte_end_i | input | 1 | End-of-byte strobe |
| mst_o | output | 1 | Master mode bit |
| trx_o | output | 1 | Transmit mode bit |
| al_o | output | 1 | Sticky arbitration-lost flag |
| sda_rel_o | output | 1 | Release request to pad logic for the rest of the byte |

## Verification
The assertions assume that the sample strobe and the end-of-byte strobe are synchronous single-cycle pulses. They also assume that the mode bits change only through the mode write strobe. Apart from that, they permit any combination of strobes. The stimulus changes every input just after a falling edge and holds the line level steady for more than SYNC_STAGES cycles before a strobe, except in the test aimed at synchronizer latency. The sweep covers all 64 combinations of enable, master, transmit, driven level, line level and strobe. Each combination starts from reset, so no earlier pending loss affects the next one.

// File: rtl/i2c_arb_pkg.sv
`timescale 1ns/1ps
package i2c_arb_pkg;
  typedef struct packed {
    logic mst;
    logic trx;
  } mode_t;
  localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/arb_sync.sv
`timescale 1ns/1ps
module arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

  // R1: output follows input exactly STAGES edges later (checked at one stage depth)
  p_sync_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sh_q[0] == $past(d_i));
endmodule

// File: rtl/arb_cmp.sv
`timescale 1ns/1ps
module arb_cmp
  import i2c_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  mode_t mode_i,
  input  logic  sda_drv_i,
  input  logic  sda_s_i,
  input  logic  stb_i,
  input  logic  dsr_wr_i,
  output logic  loss_o,
  output logic  al_o
);
  logic al_q;

  // line released by us but seen low while we own the bus as transmitter
  assign loss_o = en_i & mode_i.mst & mode_i.trx & stb_i & sda_drv_i & ~sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       al_q <= 1'b0;
    else if (!en_i)    al_q <= 1'b0;
    else if (loss_o)   al_q <= 1'b1;
    else if (dsr_wr_i) al_q <= 1'b0;
  end

  assign al_o = al_q;

  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_o |=> al_q);
  p_clr_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dsr_wr_i && !loss_o |=> !al_q);
  p_clr_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !al_q);
endmodule

// File: rtl/arb_mode.sv
`timescale 1ns/1ps
module arb_mode
  import i2c_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  mode_wr_i,
  input  mode_t mode_wdat_i,
  input  logic  loss_i,
  input  logic  byte_end_i,
  output mode_t mode_o,
  output logic  rel_o
);
  mode_t mode_q;
  logic  pend_q;
  logic  drop_mst;

  assign drop_mst = byte_end_i & (pend_q | loss_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (!en_i)      pend_q <= 1'b0;
    else if (byte_end_i) pend_q <= 1'b0;
    else if (loss_i)     pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q.trx <= 1'b0;
    else if (loss_i)    mode_q.trx <= 1'b0;
    else if (mode_wr_i) mode_q.trx <= mode_wdat_i.trx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q.mst <= 1'b0;
    else if (drop_mst)  mode_q.mst <= 1'b0;
    else if (mode_wr_i) mode_q.mst <= mode_wdat_i.mst;
  end

  assign mode_o = mode_q;
  assign rel_o  = pend_q;

  p_trx_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_i |=> !mode_q.trx);
  p_mst_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !byte_end_i && !mode_wr_i |=> $stable(mode_q.mst));
  p_mst_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end_i && (pend_q || loss_i) |=> !mode_q.mst);
  p_rel_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_i && !byte_end_i |=> pend_q);
  p_rel_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end_i |=> !pend_q);
endmodule

// File: rtl/i2c_arb_monitor.sv
`timescale 1ns/1ps
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_wr_i,
  input  logic mst_wdat_i,
  input  logic trx_wdat_i,
  input  logic dsr_wr_i,
  input  logic sda_drv_i,
  input  logic sda_line_i,
  input  logic scl_hi_stb_i,
  input  logic byte_end_i,
  output logic mst_o,
  output logic trx_o,
  output logic al_o,
  output logic sda_rel_o
);
  mode_t mode;
  mode_t wdat;
  logic  sda_s;
  logic  loss;

  initial begin
    a_stages_r1: assert (SYNC_STAGES >= SYNC_MIN);
  end

  assign wdat.mst = mst_wdat_i;
  assign wdat.trx = trx_wdat_i;

  arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_line_i),
    .q_o   (sda_s)
  );

  arb_cmp u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode),
    .sda_drv_i(sda_drv_i),
    .sda_s_i  (sda_s),
    .stb_i    (scl_hi_stb_i),
    .dsr_wr_i (dsr_wr_i),
    .loss_o   (loss),
    .al_o     (al_o)
  );

  arb_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_wr_i  (mode_wr_i),
    .mode_wdat_i(wdat),
    .loss_i     (loss),
    .byte_end_i (byte_end_i),
    .mode_o     (mode),
    .rel_o      (sda_rel_o)
  );

  assign mst_o = mode.mst;
  assign trx_o = mode.trx;

  p_no_det_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mst_o && trx_o) |=> !$rose(al_o));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_o && en_i && !dsr_wr_i |=> al_o);
  p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && !loss && !byte_end_i |=> trx_o == $past(trx_wdat_i));
endmodule

// File: tb/sim_i2c_arb_monitor.sv
`timescale 1ns/1ps
module sim_i2c_arb_monitor;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en, mode_wr, mst_w, trx_w, dsr_wr, drv, line, stb, bend;
  logic mst, trx, al, rel;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  i2c_arb_monitor #(.SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_wr_i(mode_wr),
    .mst_wdat_i(mst_w), .trx_wdat_i(trx_w), .dsr_wr_i(dsr_wr),
    .sda_drv_i(drv), .sda_line_i(line), .scl_hi_stb_i(stb),
    .byte_end_i(bend), .mst_o(mst), .trx_o(trx), .al_o(al), .sda_rel_o(rel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; en = 0; mode_wr = 0; mst_w = 0; trx_w = 0; dsr_wr = 0;
    drv = 1; line = 1; stb = 0; bend = 0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  // enable, load master+transmit, settle line high
  task automatic setup_mt();
    do_reset();
    en = 1; mode_wr = 1; mst_w = 1; trx_w = 1;
    tick();
    mode_wr = 0;
    tick(); tick(); tick();
  endtask

  task automatic force_loss();
    line = 0; tick(); tick(); tick();
    drv = 1; stb = 1; tick(); stb = 0;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    rst_ni = 0; #1;
    chk("R7 reset al", al, 0); chk("R7 reset mst", mst, 0);
    chk("R7 reset trx", trx, 0); chk("R7 reset rel", rel, 0);
    tick(); rst_ni = 1; tick();

    // R2/R5 sweep over all detection inputs
    for (int idx = 0; idx < 64; idx++) begin
      logic e, m, t, d, s, b, exp_l;
      e = idx[0]; m = idx[1]; t = idx[2]; d = idx[3]; s = idx[4]; b = idx[5];
      exp_l = e & m & t & d & ~s & b;
      do_reset();
      en = e; mode_wr = 1; mst_w = m; trx_w = t;
      tick();
      chk("R10 mst load", mst, m); chk("R10 trx load", trx, t);
      mode_wr = 0; line = s;
      tick(); tick(); tick();
      drv = d; stb = b;
      tick();
      stb = 0;
      chk("R2/R5 al", al, exp_l);
      chk("R3/R5 trx", trx, t & ~exp_l);
      chk("R4/R5 mst held", mst, m);
      chk("R8 rel", rel, exp_l);
      bend = 1; tick(); bend = 0;
      chk("R4 mst at byte end", mst, m & ~exp_l);
      chk("R8 rel cleared", rel, 0);
      chk("R3 al sticky", al, exp_l);
    end

    // R1 synchronizer latency
    setup_mt();
    line = 0; tick();
    drv = 1; stb = 1; tick();
    chk("R1 late change unseen", al, 0);
    tick();
    chk("R1 seen after stages", al, 1);
    stb = 0;

    // R4 hold over many cycles, R8 release held
    setup_mt();
    force_loss();
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R4 mst hold", mst, 1);
      chk("R8 rel hold", rel, 1);
    end

    // R9 mode write keeps flag, R10 load
    mode_wr = 1; mst_w = 1; trx_w = 1; tick(); mode_wr = 0;
    chk("R9 al after mode write", al, 1);
    chk("R10 trx reloaded", trx, 1);

    // R6 clear by shift register write
    dsr_wr = 1; tick(); dsr_wr = 0;
    chk("R6 al cleared by write", al, 0);

    // R7 clear by enable low
    setup_mt();
    force_loss();
    chk("R7 al set first", al, 1);
    en = 0; tick();
    chk("R7 al cleared by enable", al, 0);
    chk("R8 rel cleared by enable", rel, 0);
    en = 1;

    // R10 loss wins over simultaneous mode write
    setup_mt();
    line = 0; tick(); tick(); tick();
    stb = 1; mode_wr = 1; mst_w = 1; trx_w = 1; tick();
    stb = 0; mode_wr = 0;
    chk("R10 loss beats write", trx, 0);
    chk("R3 al on loss with write", al, 1);

    // R4 loss and byte end together
    setup_mt();
    line = 0; tick(); tick(); tick();
    stb = 1; bend = 1; tick(); stb = 0; bend = 0;
    chk("R4 same-edge drop", mst, 0);
    chk("R8 no release same edge", rel, 0);
    chk("R3 al same edge", al, 1);

    // R6 write with loss same edge: flag set
    setup_mt();
    line = 0; tick(); tick(); tick();
    stb = 1; dsr_wr = 1; tick(); stb = 0; dsr_wr = 0;
    chk("R6 loss beats clear", al, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule